// File: doc/BRIEF.md
# Split Exact/Approximate Final-Stage Adder

This block performs the last addition of a reduction-based multiplier. Two 2N-bit addends are added one bit position at a time. A configurable number m of the least significant positions are handled cheaply. In that region the carry out of every position is still computed exactly as the majority of the two addend bits and the incoming carry. The sum bit of each such position is taken as the complement of its carry out.

The remaining k = 2N − m upper positions use a full exact adder. That adder starts from the exact carry that leaves the relaxed region, so an error made in a low bit never moves upward. The result wraps modulo 2^(2N). The carry into bit 0 is zero.

Latency follows a piecewise cost model. A relaxed position costs 2 cycles, and one extra cycle inverts all relaxed carries into sum bits at once. An exact position costs 13 cycles. A pulse on the start input launches an operation. A one-cycle done pulse marks the result, and a cycle counter reports how many cycles the operation took.

Top module: `split_final_adder`

## Requirements
- R1: The carry out of every bit position i is MAJ(a[i], b[i], c[i]) = a·b + b·c + c·a, computed exactly in both regions. The carry into bit 0 is 0, and the carry out of bit 2N−1 is discarded.
- R2: For every relaxed bit i < m, sum_o[i] equals the inverse of the exact carry out of position i. This is wrong only when a[i], b[i] and c[i] are all 0 or all 1.
- R3: Bits [2N−1:m] of sum_o equal the exact sum of a[2N−1:m] + b[2N−1:m] plus the true carry into bit m, modulo 2^(2N−m).
- R4: relax_grp_i counts relaxed bits in groups of 4, so m = 4·relax_grp_i. A value above min(MAX_RELAX, 2N)/4 is clamped to that limit, which is 8 groups (32 bits) by default. The value is sampled when start is accepted.
- R5: Let L = 13·(2N − m) + 2·m + (m > 0 ? 1 : 0). done_o is high exactly L clock edges after the edge that accepts start, and at that moment cycles_o equals L.
- R6: With m = 0 the block is a plain exact adder: sum_o = (a + b) mod 2^(2N), and the latency is 13·2N cycles.
- R7: done_o is a single-cycle pulse. While idle with no start, sum_o and cycles_o hold their values.
- R8: A start pulse while an operation is in progress is ignored. Neither the running result nor its latency changes.
- R9: After synchronous reset, done_o = 0, cycles_o = 0 and sum_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, accepted only while idle |
| addend_a_i | input | 2·HALF_W | First addend |
| addend_b_i | input | 2·HALF_W | Second addend |
| relax_grp_i | input | clog2(MAX_RELAX/4+1) | Number of 4-bit relaxed groups at the bottom |
| sum_o | output | 2·HALF_W | Result, valid from the done pulse until the next accepted start |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | clog2(13·2·HALF_W+2) | Busy cycles of the current or last operation |

## Verification
The hardest cases to reach are those where a relaxed position sees all-zero or all-one inputs while its exact carry still matters above the boundary. Random data rarely places a long carry chain exactly across bit m. The stimulus therefore adds directed operands on top of seeded random ones: all zeros, all ones, and both fully relaxed and fully exact settings. It also includes a group count above the clamp limit and a second start pulse issued mid-operation with different operands.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int EXACT_STEPS  = 13;
    localparam int APPROX_STEPS = 2;
    localparam int GROUP_BITS   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RELAX,
        ST_FLIP,
        ST_EXACT
    } seq_state_e;

    typedef struct packed {
        logic a;
        logic b;
        logic cin;
    } bit_in_t;

    typedef struct packed {
        logic sum;
        logic cout;
    } bit_out_t;

    function automatic logic maj3(bit_in_t x);
        return (x.a & x.b) | (x.b & x.cin) | (x.cin & x.a);
    endfunction

    function automatic logic par3(bit_in_t x);
        return x.a ^ x.b ^ x.cin;
    endfunction

    function automatic int span_cycles(int width, int relaxed);
        return EXACT_STEPS * (width - relaxed) + APPROX_STEPS * relaxed
               + ((relaxed != 0) ? 1 : 0);
    endfunction

endpackage

// File: rtl/sfa_bitcell.sv
module sfa_bitcell
    import sfa_pkg::*;
(
    input  bit_in_t  in_i,
    output bit_out_t out_o
);
    // Carry is exact in both regions; the sum bit is used only in the exact region.
    always_comb begin
        out_o.cout = maj3(in_i);
        out_o.sum  = par3(in_i);
    end
endmodule

// File: rtl/sfa_relax_decode.sv
module sfa_relax_decode
    import sfa_pkg::*;
#(
    parameter int W         = 32,
    parameter int MAX_RELAX = 32,
    parameter int GW        = 4,
    parameter int IW        = 6
) (
    input  logic [GW-1:0] grp_i,
    output logic [IW-1:0] relax_bits_o
);
    localparam int LIMIT    = (MAX_RELAX < W) ? MAX_RELAX : W;
    localparam int CAP_GRP  = LIMIT / GROUP_BITS;
    localparam int CAP_BITS = CAP_GRP * GROUP_BITS;

    always_comb begin
        if (int'(grp_i) > CAP_GRP)
            relax_bits_o = IW'(CAP_BITS);
        else
            relax_bits_o = IW'(int'(grp_i) * GROUP_BITS);
    end
endmodule

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
    import sfa_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 6,
    parameter int LW = 5,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [IW-1:0] relax_bits_i,
    output logic          load_o,
    output logic          commit_o,
    output logic          relaxed_o,
    output logic          flip_o,
    output logic [LW-1:0] bit_idx_o,
    output logic [IW-1:0] relax_q_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] cycles_o
);
    localparam int SW = $clog2(EXACT_STEPS);
    localparam logic [SW-1:0] EXACT_LAST  = SW'(EXACT_STEPS - 1);
    localparam logic [SW-1:0] APPROX_LAST = SW'(APPROX_STEPS - 1);

    seq_state_e    state_q;
    logic [IW-1:0] bit_q;
    logic [IW-1:0] relax_q;
    logic [SW-1:0] sub_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            relax_q <= '0;
            sub_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        relax_q <= relax_bits_i;
                        bit_q   <= '0;
                        sub_q   <= '0;
                        cnt_q   <= '0;
                        state_q <= (relax_bits_i != '0) ? ST_RELAX : ST_EXACT;
                    end
                end
                ST_RELAX: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (sub_q == APPROX_LAST) begin
                        sub_q <= '0;
                        bit_q <= bit_q + IW'(1);
                        if (bit_q == relax_q - IW'(1))
                            state_q <= ST_FLIP;
                    end else begin
                        sub_q <= sub_q + SW'(1);
                    end
                end
                ST_FLIP: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (relax_q == IW'(W)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_EXACT;
                    end
                end
                ST_EXACT: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (sub_q == EXACT_LAST) begin
                        sub_q <= '0;
                        bit_q <= bit_q + IW'(1);
                        if (bit_q == IW'(W - 1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else begin
                        sub_q <= sub_q + SW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_o    = (state_q == ST_IDLE) && start_i;
        relaxed_o = (state_q == ST_RELAX);
        flip_o    = (state_q == ST_FLIP);
        commit_o  = ((state_q == ST_RELAX) && (sub_q == APPROX_LAST)) ||
                    ((state_q == ST_EXACT) && (sub_q == EXACT_LAST));
        busy_o    = (state_q != ST_IDLE);
        bit_idx_o = bit_q[LW-1:0];
        relax_q_o = relax_q;
        done_o    = done_q;
        cycles_o  = cnt_q;
    end
endmodule

// File: rtl/sfa_store.sv
module sfa_store
    import sfa_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 6,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          commit_i,
    input  logic          relaxed_i,
    input  logic          flip_i,
    input  logic [LW-1:0] bit_idx_i,
    input  logic [IW-1:0] relax_bits_i,
    output logic [W-1:0]  sum_o
);
    logic [W-1:0] a_q, b_q, cvec_q, sum_q, low_mask;
    logic         carry_q;
    bit_in_t      cell_in;
    bit_out_t     cell_out;

    generate
        for (genvar i = 0; i < W; i++) begin : g_mask
            assign low_mask[i] = (IW'(i) < relax_bits_i);
        end
    endgenerate

    assign cell_in = '{a: a_q[bit_idx_i], b: b_q[bit_idx_i], cin: carry_q};

    sfa_bitcell u_cell (
        .in_i  (cell_in),
        .out_o (cell_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            cvec_q  <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else if (load_i) begin
            a_q     <= a_i;
            b_q     <= b_i;
            cvec_q  <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else if (commit_i) begin
            carry_q <= cell_out.cout;
            if (relaxed_i)
                cvec_q[bit_idx_i] <= cell_out.cout;
            else
                sum_q[bit_idx_i]  <= cell_out.sum;
        end else if (flip_i) begin
            sum_q <= (sum_q & ~low_mask) | (~cvec_q & low_mask);
        end
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/split_final_adder.sv
module split_final_adder
    import sfa_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int MAX_RELAX = 32
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            start_i,
    input  logic [2*HALF_W-1:0]                             addend_a_i,
    input  logic [2*HALF_W-1:0]                             addend_b_i,
    input  logic [$clog2(MAX_RELAX/GROUP_BITS+1)-1:0]       relax_grp_i,
    output logic [2*HALF_W-1:0]                             sum_o,
    output logic                                            done_o,
    output logic [$clog2(EXACT_STEPS*2*HALF_W+2)-1:0]       cycles_o
);
    localparam int W  = 2 * HALF_W;
    localparam int IW = $clog2(W + 1);
    localparam int LW = $clog2(W);
    localparam int GW = $clog2(MAX_RELAX / GROUP_BITS + 1);
    localparam int CW = $clog2(EXACT_STEPS * W + 2);

    logic [IW-1:0] relax_bits_w, relax_q_w;
    logic [LW-1:0] bit_idx_w;
    logic          load_w, commit_w, relaxed_w, flip_w, busy_w;

    sfa_relax_decode #(.W(W), .MAX_RELAX(MAX_RELAX), .GW(GW), .IW(IW)) u_dec (
        .grp_i        (relax_grp_i),
        .relax_bits_o (relax_bits_w)
    );

    sfa_ctrl #(.W(W), .IW(IW), .LW(LW), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .relax_bits_i (relax_bits_w),
        .load_o       (load_w),
        .commit_o     (commit_w),
        .relaxed_o    (relaxed_w),
        .flip_o       (flip_w),
        .bit_idx_o    (bit_idx_w),
        .relax_q_o    (relax_q_w),
        .busy_o       (busy_w),
        .done_o       (done_o),
        .cycles_o     (cycles_o)
    );

    sfa_store #(.W(W), .IW(IW), .LW(LW)) u_store (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_w),
        .a_i          (addend_a_i),
        .b_i          (addend_b_i),
        .commit_i     (commit_w),
        .relaxed_i    (relaxed_w),
        .flip_i       (flip_w),
        .bit_idx_i    (bit_idx_w),
        .relax_bits_i (relax_q_w),
        .sum_o        (sum_o)
    );
endmodule

// File: rtl/sfa_checker.sv
module sfa_checker
    import sfa_pkg::*;
#(
    parameter int W         = 32,
    parameter int GW        = 4,
    parameter int CW        = 9,
    parameter int MAX_RELAX = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [GW-1:0] relax_grp_i,
    input logic [W-1:0]  sum_o,
    input logic          done_o,
    input logic [CW-1:0] cycles_o,
    input logic          busy_i
);
    localparam int LIMIT = (MAX_RELAX < W) ? MAX_RELAX : W;
    localparam int CAPG  = LIMIT / GROUP_BITS;

    int m_chk;

    always_ff @(posedge clk) begin
        if (rst)
            m_chk <= 0;
        else if (start_i && !busy_i)
            m_chk <= ((int'(relax_grp_i) > CAPG) ? CAPG : int'(relax_grp_i)) * GROUP_BITS;
    end

    // R5
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> int'(cycles_o) == span_cycles(W, m_chk));

    // R6
    exact_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && m_chk == 0) |-> int'(cycles_o) == EXACT_STEPS * W);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && !start_i) |=> ($stable(sum_o) && $stable(cycles_o)));

    // R8
    busy_count_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> cycles_o == $past(cycles_o) + CW'(1));

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done_o && cycles_o == '0 && sum_o == '0));
endmodule

bind split_final_adder sfa_checker #(
    .W(W), .GW(GW), .CW(CW), .MAX_RELAX(MAX_RELAX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .relax_grp_i (relax_grp_i),
    .sum_o       (sum_o),
    .done_o      (done_o),
    .cycles_o    (cycles_o),
    .busy_i      (busy_w)
);

// File: tb/split_final_adder_test.sv
module split_final_adder_test;
    localparam int HALF_W = 16;
    localparam int W      = 2 * HALF_W;
    localparam int GW     = 4;
    localparam int CW     = $clog2(13 * W + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [W-1:0]  a_in = '0, b_in = '0;
    logic [GW-1:0] grp_in = '0;
    logic [W-1:0]  sum_o;
    logic          done_o;
    logic [CW-1:0] cycles_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    split_final_adder #(.HALF_W(HALF_W), .MAX_RELAX(32)) uut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .addend_a_i  (a_in),
        .addend_b_i  (b_in),
        .relax_grp_i (grp_in),
        .sum_o       (sum_o),
        .done_o      (done_o),
        .cycles_o    (cycles_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int relaxed_of(int grp);
        return ((grp > 8) ? 8 : grp) * 4;
    endfunction

    function automatic int lat_of(int m);
        return 13 * (W - m) + 2 * m + ((m != 0) ? 1 : 0);
    endfunction

    function automatic logic [63:0] carry_into(logic [63:0] a, logic [63:0] b, int i);
        logic [63:0] mask = (64'd1 << i) - 64'd1;
        return (((a & mask) + (b & mask)) >> i) & 64'd1;
    endfunction

    function automatic logic [63:0] low_expect(logic [63:0] a, logic [63:0] b, int m);
        logic [63:0] r = '0;
        for (int i = 0; i < m; i++) begin
            logic x = a[i], y = b[i], c = carry_into(a, b, i)[0];
            r[i] = ~((x & y) | (y & c) | (c & x));
        end
        return r;
    endfunction

    function automatic logic [63:0] high_expect(logic [63:0] a, logic [63:0] b, int m);
        logic [63:0] wmask = (64'd1 << W) - 64'd1;
        if (m >= W) return '0;
        return (((a >> m) + (b >> m) + carry_into(a, b, m)) << m) & wmask;
    endfunction

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int grp, input bit poke);
        int m = relaxed_of(grp);
        int L = lat_of(m);
        int n = 0;
        logic [63:0] lmask = (64'd1 << m) - 64'd1;
        logic [W-1:0] held;
        @(negedge clk);
        start_i = 1'b1; a_in = a; b_in = b; grp_in = GW'(grp);
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
            if (poke && n == 5) begin
                start_i = 1'b1; a_in = ~a; b_in = a ^ b; grp_in = '0;
            end
            if (poke && n == 6) start_i = 1'b0;
        end
        check(n == L, poke ? "R8" : "R5", "done latency", 64'(n), 64'(L));
        check(int'(cycles_o) == L, "R5", "cycles_o", 64'(cycles_o), 64'(L));
        check((64'(sum_o) & lmask) == low_expect(64'(a), 64'(b), m), "R2",
              "relaxed low bits", 64'(sum_o) & lmask, low_expect(64'(a), 64'(b), m));
        check((64'(sum_o) & ~lmask) == high_expect(64'(a), 64'(b), m), "R3",
              "exact high bits", 64'(sum_o) & ~lmask, high_expect(64'(a), 64'(b), m));
        held = sum_o;
        @(negedge clk);
        check(done_o == 1'b0, "R7", "done pulse width", 64'(done_o), 64'd0);
        check(sum_o == held, "R7", "sum held", 64'(sum_o), 64'(held));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int unsigned seed_set;
        seed_set = $urandom(32'd7321);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(done_o == 1'b0, "R9", "done after reset", 64'(done_o), 64'd0);
        check(cycles_o == '0, "R9", "cycles after reset", 64'(cycles_o), 64'd0);
        check(sum_o == '0, "R9", "sum after reset", 64'(sum_o), 64'd0);

        // R6 / R1: exact mode, top carry discarded
        run_op('1, '1, 0, 1'b0);
        check(sum_o == W'(32'hFFFF_FFFE), "R1", "carry dropped", 64'(sum_o), 64'hFFFF_FFFE);
        check(int'(cycles_o) == 13 * W, "R6", "exact latency", 64'(cycles_o), 64'(13 * W));
        run_op(32'h1234_5678, 32'h8765_4321, 0, 1'b0);
        check(sum_o == W'(32'h1234_5678 + 32'h8765_4321), "R6", "exact sum",
              64'(sum_o), 64'(W'(32'h1234_5678 + 32'h8765_4321)));

        // R2 all-zero case: relaxed bits become ones
        run_op('0, '0, 2, 1'b0);
        check(sum_o == W'(32'h0000_00FF), "R2", "zero operands", 64'(sum_o), 64'hFF);
        // all-one case fully relaxed
        run_op('1, '1, 8, 1'b0);
        check(sum_o == '0, "R2", "all ones relaxed", 64'(sum_o), 64'd0);
        // R4 clamp of group count above limit
        run_op(32'h0F0F_0F0F, 32'h00FF_00FF, 15, 1'b0);
        check(int'(cycles_o) == lat_of(32), "R4", "clamped latency",
              64'(cycles_o), 64'(lat_of(32)));
        run_op(32'h0000_000F, 32'h0000_0001, 1, 1'b0);
        // R3 carry crossing boundary m=4
        check(sum_o[W-1:4] == W'(1) >> 0, "R3", "boundary carry",
              64'(sum_o[W-1:4]), 64'd1);

        // R8 start while busy ignored
        run_op(32'hDEAD_BEEF, 32'h1357_9BDF, 3, 1'b1);
        run_op(32'hAAAA_5555, 32'h5555_AAAA, 0, 1'b1);

        // constrained random
        for (int t = 0; t < 50; t++) begin
            run_op(W'($urandom), W'($urandom), int'($urandom_range(0, 10)), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule